// File: doc/BRIEF.md
# Dual-Thread Instruction Queue with Compare-Branch Fusion

This block sits between an instruction pre-decoder and a bank of four decoders. Each of two hardware threads owns a private circular queue of pre-decoded instruction records. The writer delivers a bundle of up to six records per cycle, all tagged with one thread number. Each record carries a class code and an opaque payload.

Every cycle the block picks one thread and forms a group for the four decoder slots. A compare/test or a counter update that sits directly before a conditional jump in the same thread's queue is merged into one slot marked fused, so a group can consume five records. Only one merge is allowed per group. Slot 0 feeds the only complex-capable decoder, so a complex record can only go in slot 0. The threads take turns each cycle. A thread with nothing queued yields its turn to the other. Each queue raises backpressure to the writer when fewer than six entries are free, and each can be flushed alone.

Top module: `iq_fuse_dispatch`

## Requirements
- R1: After reset both queues are empty, no decoder slot is valid and both backpressure bits are low.
- R2: Each thread queue holds 20 entries. `wr_full[t]` is high exactly when thread t has 15 or more entries, that is, fewer than 6 free.
- R3: Records written with thread number t are delivered only with `dec_tid` = t, in the order in which they were written. Within a bundle, lane 0 comes first.
- R4: Valid slots form a prefix starting at slot 0, and a group has at most 4 slots. A group is formed from the queue contents registered at one clock edge and appears on the outputs at the next edge.
- R5: Class codes are 0 plain, 1 compare/test, 2 counter update, 3 conditional jump and 4 complex. A record of class 1 or 2 that is directly followed in its queue by a class 3 record occupies a single slot with `dec_fused` high. That slot carries the first record's class and payload on `dec_data`, and the jump's payload on `dec_data_b`.
- R6: At most one fused slot appears per group. A later eligible pair in the same group goes out as separate unfused slots.
- R7: When one pair is fused, a group of four slots consumes five records.
- R8: A class 4 record is placed only in slot 0. A class 4 record that would land in slot 1 to 3 ends the group, and it heads a later group.
- R9: When both queues hold records, groups alternate threads on consecutive cycles. When the thread whose turn it is has an empty queue, the other thread is served in that cycle.
- R10: `flush[t]` empties thread t's queue, including any records written in the same cycle. Thread t sends no group in the cycle after the flush. The other thread's records and their order are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_vld | input | 6 | Per-lane valid of the incoming bundle |
| wr_tid | input | 1 | Thread number of the incoming bundle |
| wr_cls | input | 18 | Class code per lane, 3 bits each, lane 0 in the low bits |
| wr_data | input | 48 | Payload per lane, 8 bits each |
| flush | input | 2 | Per-thread queue flush |
| wr_full | output | 2 | Per-thread backpressure (fewer than 6 entries free) |
| dec_vld | output | 4 | Decoder slot valid |
| dec_tid | output | 1 | Thread of the current group |
| dec_cls | output | 12 | Class per slot, 3 bits each |
| dec_data | output | 32 | Payload per slot (first record of a fused pair) |
| dec_data_b | output | 32 | Jump payload of a fused slot |
| dec_fused | output | 4 | Slot holds a fused compare-and-branch pair |

## Verification
The backpressure boundary is the hardest state to reach. The queues drain on their own every cycle, so an entry count of 15 or more builds up only when the writer outpaces dispatch. The stimulus fills both threads with complex-only bundles written on alternate cycles. Each such group then drains a single record per turn while six arrive, which pushes each queue up to and past the threshold. A running count of pushes minus delivered records is then compared with `wr_full` on every cycle. Grouping cases (fusion position, second pairs, complex placement, jump not yet arrived) are each placed in an otherwise empty queue, so the first group they produce is fully predictable.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int CLS_W = 3;
    localparam logic [CLS_W-1:0] CLS_PLAIN = 3'd0;
    localparam logic [CLS_W-1:0] CLS_CMP   = 3'd1;
    localparam logic [CLS_W-1:0] CLS_CNT   = 3'd2;
    localparam logic [CLS_W-1:0] CLS_JCC   = 3'd3;
    localparam logic [CLS_W-1:0] CLS_CPLX  = 3'd4;

    // head of a fusable pair: compare/test or counter update
    function automatic logic pair_head(input logic [CLS_W-1:0] c);
        return (c == CLS_CMP) || (c == CLS_CNT);
    endfunction
endpackage

// File: rtl/iq_thread_queue.sv
module iq_thread_queue
    import iq_pkg::*;
#(
    parameter int DEPTH    = 20,
    parameter int WR_LANES = 6,
    parameter int WIN      = 5,
    parameter int DW       = 8,
    parameter int BP_FREE  = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push_en,
    input  logic [WR_LANES-1:0]             push_vld,
    input  logic [WR_LANES-1:0][CLS_W-1:0]  push_cls,
    input  logic [WR_LANES-1:0][DW-1:0]     push_data,
    input  logic [$clog2(WIN+1)-1:0]        pop_n,
    input  logic                            flush,
    output logic [WIN-1:0][CLS_W-1:0]       win_cls,
    output logic [WIN-1:0][DW-1:0]          win_data,
    output logic [$clog2(WIN+1)-1:0]        avail,
    output logic                            bp
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int NW = $clog2(WIN + 1);

    typedef struct packed {
        logic [DEPTH-1:0][CLS_W-1:0] cls;
        logic [DEPTH-1:0][DW-1:0]    data;
        logic [PW-1:0]               head;
        logic [CW-1:0]               count;
    } q_t;

    q_t q_q, q_d;

    always_comb begin
        int fill;
        int slot;
        int nhead;
        q_d   = q_q;
        fill  = 0;
        slot  = 0;
        nhead = 0;
        if (flush) begin
            q_d.count = '0;
        end else begin
            nhead     = (int'(q_q.head) + int'(pop_n)) % DEPTH;
            q_d.head  = PW'(nhead);
            fill      = int'(q_q.count) - int'(pop_n);
            for (int l = 0; l < WR_LANES; l++) begin
                if (push_en && push_vld[l] && fill < DEPTH) begin
                    slot              = (nhead + fill) % DEPTH;
                    q_d.cls[slot]     = push_cls[l];
                    q_d.data[slot]    = push_data[l];
                    fill              = fill + 1;
                end
            end
            q_d.count = CW'(fill);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_comb begin
        int idx;
        idx = 0;
        for (int k = 0; k < WIN; k++) begin
            idx         = (int'(q_q.head) + k) % DEPTH;
            win_cls[k]  = q_q.cls[idx];
            win_data[k] = q_q.data[idx];
        end
        avail = (int'(q_q.count) < WIN) ? NW'(q_q.count) : NW'(WIN);
        bp    = (DEPTH - int'(q_q.count)) < BP_FREE;
    end
endmodule

// File: rtl/iq_group_former.sv
module iq_group_former
    import iq_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int WIN   = SLOTS + 1,
    parameter int DW    = 8
) (
    input  logic [WIN-1:0][CLS_W-1:0]   win_cls,
    input  logic [WIN-1:0][DW-1:0]      win_data,
    input  logic [$clog2(WIN+1)-1:0]    avail,
    output logic [SLOTS-1:0]            sl_vld,
    output logic [SLOTS-1:0][CLS_W-1:0] sl_cls,
    output logic [SLOTS-1:0][DW-1:0]    sl_data,
    output logic [SLOTS-1:0][DW-1:0]    sl_data_b,
    output logic [SLOTS-1:0]            sl_fused,
    output logic [$clog2(WIN+1)-1:0]    take
);
    localparam int NW = $clog2(WIN + 1);

    always_comb begin
        int   idx;
        logic merged;
        logic stop;
        idx       = 0;
        merged    = 1'b0;
        stop      = 1'b0;
        sl_vld    = '0;
        sl_cls    = '0;
        sl_data   = '0;
        sl_data_b = '0;
        sl_fused  = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!stop && idx < int'(avail)) begin
                if (win_cls[idx] == CLS_CPLX && s != 0) begin
                    stop = 1'b1;
                end else begin
                    sl_vld[s]  = 1'b1;
                    sl_cls[s]  = win_cls[idx];
                    sl_data[s] = win_data[idx];
                    if (!merged && pair_head(win_cls[idx]) &&
                        (idx + 1) < int'(avail) && win_cls[idx+1] == CLS_JCC) begin
                        sl_fused[s]  = 1'b1;
                        sl_data_b[s] = win_data[idx+1];
                        merged       = 1'b1;
                        idx          = idx + 2;
                    end else begin
                        idx = idx + 1;
                    end
                end
            end
        end
        take = NW'(idx);
    end
endmodule

// File: rtl/iq_fuse_dispatch.sv
module iq_fuse_dispatch
    import iq_pkg::*;
#(
    parameter int DEPTH    = 20,
    parameter int WR_LANES = 6,
    parameter int SLOTS    = 4,
    parameter int DW       = 8,
    parameter int BP_FREE  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WR_LANES-1:0]       wr_vld,
    input  logic                      wr_tid,
    input  logic [WR_LANES*CLS_W-1:0] wr_cls,
    input  logic [WR_LANES*DW-1:0]    wr_data,
    input  logic [1:0]                flush,
    output logic [1:0]                wr_full,
    output logic [SLOTS-1:0]          dec_vld,
    output logic                      dec_tid,
    output logic [SLOTS*CLS_W-1:0]    dec_cls,
    output logic [SLOTS*DW-1:0]       dec_data,
    output logic [SLOTS*DW-1:0]       dec_data_b,
    output logic [SLOTS-1:0]          dec_fused
);
    localparam int NT  = 2;
    localparam int WIN = SLOTS + 1;
    localparam int NW  = $clog2(WIN + 1);

    typedef struct packed {
        logic                            last;
        logic [SLOTS-1:0]                vld;
        logic                            tid;
        logic [SLOTS-1:0][CLS_W-1:0]     cls;
        logic [SLOTS-1:0][DW-1:0]        data;
        logic [SLOTS-1:0][DW-1:0]        data_b;
        logic [SLOTS-1:0]                fused;
    } st_t;

    st_t st_q, st_d;

    logic [WR_LANES-1:0][CLS_W-1:0]      in_cls;
    logic [WR_LANES-1:0][DW-1:0]         in_data;
    logic [NT-1:0][WIN-1:0][CLS_W-1:0]   t_cls;
    logic [NT-1:0][WIN-1:0][DW-1:0]      t_data;
    logic [NT-1:0][NW-1:0]               t_avail;
    logic [NT-1:0][NW-1:0]               t_pop;
    logic [NT-1:0]                       ready;
    logic                                sel, any;

    logic [SLOTS-1:0]                    g_vld, g_fused;
    logic [SLOTS-1:0][CLS_W-1:0]         g_cls;
    logic [SLOTS-1:0][DW-1:0]            g_data, g_data_b;
    logic [NW-1:0]                       g_take;

    assign in_cls  = wr_cls;
    assign in_data = wr_data;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        iq_thread_queue #(
            .DEPTH(DEPTH), .WR_LANES(WR_LANES), .WIN(WIN), .DW(DW), .BP_FREE(BP_FREE)
        ) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_en  (wr_tid == 1'(t)),
            .push_vld (wr_vld),
            .push_cls (in_cls),
            .push_data(in_data),
            .pop_n    (t_pop[t]),
            .flush    (flush[t]),
            .win_cls  (t_cls[t]),
            .win_data (t_data[t]),
            .avail    (t_avail[t]),
            .bp       (wr_full[t])
        );
        assign ready[t] = (t_avail[t] != '0) && !flush[t];
        assign t_pop[t] = (any && sel == 1'(t)) ? g_take : '0;
    end

    // the thread not served last has priority; an empty turn passes over
    assign sel = ready[~st_q.last] ? ~st_q.last : st_q.last;
    assign any = |ready;

    iq_group_former #(.SLOTS(SLOTS), .WIN(WIN), .DW(DW)) u_form (
        .win_cls  (t_cls[sel]),
        .win_data (t_data[sel]),
        .avail    (t_avail[sel]),
        .sl_vld   (g_vld),
        .sl_cls   (g_cls),
        .sl_data  (g_data),
        .sl_data_b(g_data_b),
        .sl_fused (g_fused),
        .take     (g_take)
    );

    always_comb begin
        st_d = st_q;
        if (any) begin
            st_d.last   = sel;
            st_d.tid    = sel;
            st_d.vld    = g_vld;
            st_d.cls    = g_cls;
            st_d.data   = g_data;
            st_d.data_b = g_data_b;
            st_d.fused  = g_fused;
        end else begin
            st_d.vld   = '0;
            st_d.fused = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_vld    = st_q.vld;
    assign dec_tid    = st_q.tid;
    assign dec_cls    = st_q.cls;
    assign dec_data   = st_q.data;
    assign dec_data_b = st_q.data_b;
    assign dec_fused  = st_q.fused;
endmodule

// File: rtl/iq_fuse_dispatch_chk.sv
module iq_fuse_dispatch_chk
    import iq_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             flush,
    input logic [SLOTS-1:0]       dec_vld,
    input logic                   dec_tid,
    input logic [SLOTS*CLS_W-1:0] dec_cls,
    input logic [SLOTS-1:0]       dec_fused
);
    // R6
    one_fusion_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_fused));

    // R4
    vld_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld & SLOTS'(dec_vld + 1'b1)) == '0);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // R5
        fused_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dec_fused[s] |-> (dec_vld[s] && pair_head(dec_cls[s*CLS_W +: CLS_W])));
        if (s > 0) begin : g_late
            // R8
            cplx_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dec_vld[s] |-> (dec_cls[s*CLS_W +: CLS_W] != CLS_CPLX));
        end
    end

    for (genvar t = 0; t < 2; t++) begin : g_thr
        // R10
        flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush[t] |=> !(dec_vld[0] && dec_tid == 1'(t)));
    end
endmodule

bind iq_fuse_dispatch iq_fuse_dispatch_chk #(.SLOTS(SLOTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .dec_vld  (dec_vld),
    .dec_tid  (dec_tid),
    .dec_cls  (dec_cls),
    .dec_fused(dec_fused)
);

// File: tb/tb_iq_fuse_dispatch.sv
`timescale 1ns/1ps
module tb_iq_fuse_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  wr_vld = '0;
    logic        wr_tid = 1'b0;
    logic [17:0] wr_cls = '0;
    logic [47:0] wr_data = '0;
    logic [1:0]  flush = '0;
    logic [1:0]  wr_full;
    logic [3:0]  dec_vld;
    logic        dec_tid;
    logic [11:0] dec_cls;
    logic [31:0] dec_data, dec_data_b;
    logic [3:0]  dec_fused;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    iq_fuse_dispatch dut (.*);

    // classes lane5..lane0, lane count, slot-valid mask, fused mask, lane per slot (slot3..slot0)
    typedef struct packed {
        logic [5:0][2:0] cls;
        logic [2:0]      n;
        logic [3:0]      vm;
        logic [3:0]      fm;
        logic [3:0][2:0] ln;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{{3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 3'd6, 4'hF, 4'b0000, {3'd3,3'd2,3'd1,3'd0}},
        '{{3'd0,3'd0,3'd0,3'd0,3'd3,3'd1}, 3'd6, 4'hF, 4'b0001, {3'd4,3'd3,3'd2,3'd0}},
        '{{3'd0,3'd0,3'd3,3'd1,3'd3,3'd1}, 3'd6, 4'hF, 4'b0001, {3'd4,3'd3,3'd2,3'd0}},
        '{{3'd0,3'd0,3'd0,3'd3,3'd2,3'd0}, 3'd6, 4'hF, 4'b0010, {3'd4,3'd3,3'd1,3'd0}},
        '{{3'd0,3'd0,3'd0,3'd0,3'd4,3'd4}, 3'd6, 4'h1, 4'b0000, {3'd0,3'd0,3'd0,3'd0}},
        '{{3'd0,3'd0,3'd0,3'd0,3'd4,3'd0}, 3'd6, 4'h1, 4'b0000, {3'd0,3'd0,3'd0,3'd0}},
        '{{3'd0,3'd0,3'd4,3'd0,3'd0,3'd4}, 3'd6, 4'h7, 4'b0000, {3'd0,3'd2,3'd1,3'd0}},
        '{{3'd0,3'd0,3'd0,3'd0,3'd1,3'd3}, 3'd6, 4'hF, 4'b0000, {3'd3,3'd2,3'd1,3'd0}},
        '{{3'd0,3'd0,3'd0,3'd0,3'd3,3'd1}, 3'd2, 4'h1, 4'b0001, {3'd0,3'd0,3'd0,3'd0}},
        '{{3'd0,3'd0,3'd0,3'd0,3'd0,3'd1}, 3'd1, 4'h1, 4'b0000, {3'd0,3'd0,3'd0,3'd0}},
        '{{3'd0,3'd0,3'd0,3'd4,3'd3,3'd2}, 3'd6, 4'h1, 4'b0001, {3'd0,3'd0,3'd0,3'd0}},
        '{{3'd0,3'd0,3'd0,3'd3,3'd1,3'd4}, 3'd6, 4'hF, 4'b0010, {3'd4,3'd3,3'd1,3'd0}}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input bit tid, input logic [17:0] cls, input int n, input int base);
        wr_tid = tid;
        wr_cls = cls;
        for (int l = 0; l < 6; l++) begin
            wr_vld[l]         = (l < n);
            wr_data[l*8 +: 8] = 8'(base + l);
        end
    endtask

    task automatic idle();
        wr_vld = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    int sb [2][256];
    int wp [2];
    int rp [2];
    int cnt [2];
    bit sawbp;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(dec_vld == 4'h0, "R1 dec_vld", int'(dec_vld), 0);
        chk(wr_full == 2'b00, "R1 wr_full", int'(wr_full), 0);

        // grouping table: R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            push(1'b0, VECS[v].cls, int'(VECS[v].n), v * 16);
            tick();
            idle();
            tick();
            chk(dec_vld == VECS[v].vm, "R4/R8 vector slot mask", int'(dec_vld), int'(VECS[v].vm));
            chk(dec_fused == VECS[v].fm, "R5/R6 vector fused mask", int'(dec_fused), int'(VECS[v].fm));
            chk(dec_tid == 1'b0, "R3 vector thread", int'(dec_tid), 0);
            for (int s = 0; s < 4; s++) begin
                if (VECS[v].vm[s]) begin
                    chk(dec_data[s*8 +: 8] == 8'(v * 16 + int'(VECS[v].ln[s])),
                        "R7 vector slot payload", int'(dec_data[s*8 +: 8]),
                        v * 16 + int'(VECS[v].ln[s]));
                end
                if (VECS[v].fm[s]) begin
                    chk(dec_data_b[s*8 +: 8] == 8'(v * 16 + int'(VECS[v].ln[s]) + 1),
                        "R5 fused jump payload", int'(dec_data_b[s*8 +: 8]),
                        v * 16 + int'(VECS[v].ln[s]) + 1);
                end
            end
            flush = 2'b01;
            tick();
            flush = 2'b00;
            tick();
            chk(dec_vld == 4'h0, "R10 vector queue flushed", int'(dec_vld), 0);
        end

        // R9 alternation with both threads loaded
        push(1'b0, '0, 6, 8'h40);
        tick();
        push(1'b1, '0, 6, 8'h50);
        tick();
        idle();
        chk(dec_tid == 1'b0 && dec_vld == 4'hF, "R9 first group thread 0", int'(dec_tid), 0);
        tick();
        chk(dec_tid == 1'b1 && dec_vld == 4'hF, "R9 second group thread 1", int'(dec_tid), 1);
        chk(dec_data[7:0] == 8'h50, "R3 thread 1 head", int'(dec_data[7:0]), 'h50);
        tick();
        chk(dec_tid == 1'b0 && dec_vld == 4'h3, "R9 third group thread 0", int'(dec_vld), 3);
        chk(dec_data[7:0] == 8'h44, "R3 thread 0 order", int'(dec_data[7:0]), 'h44);
        tick();
        chk(dec_tid == 1'b1 && dec_vld == 4'h3, "R9 fourth group thread 1", int'(dec_vld), 3);
        tick();
        chk(dec_vld == 4'h0, "R9 both empty", int'(dec_vld), 0);

        // R9 empty turn passes to the loaded thread
        push(1'b1, '0, 6, 8'h30);
        tick();
        idle();
        tick();
        chk(dec_tid == 1'b1 && dec_vld == 4'hF, "R9 lone thread served", int'(dec_vld), 15);
        tick();
        chk(dec_tid == 1'b1 && dec_vld == 4'h3, "R9 lone thread served again", int'(dec_vld), 3);
        tick();

        // R10 flush one thread, other intact
        push(1'b0, '0, 6, 8'h60);
        tick();
        push(1'b1, '0, 6, 8'h70);
        tick();
        idle();
        chk(dec_tid == 1'b0 && dec_data[7:0] == 8'h60, "R10 pre-flush group", int'(dec_data[7:0]), 'h60);
        flush = 2'b01;
        tick();
        flush = 2'b00;
        chk(dec_tid == 1'b1 && dec_vld == 4'hF && dec_data[7:0] == 8'h70,
            "R10 other thread served", int'(dec_data[7:0]), 'h70);
        tick();
        chk(dec_tid == 1'b1 && dec_vld == 4'h3 && dec_data[7:0] == 8'h74,
            "R10 other thread intact", int'(dec_data[7:0]), 'h74);
        tick();
        chk(dec_vld == 4'h0, "R10 flushed thread silent", int'(dec_vld), 0);

        // R2 R3 fill with complex bundles and track occupancy
        wp = '{0, 0}; rp = '{0, 0}; cnt = '{0, 0}; sawbp = 1'b0;
        for (int cyc = 0; cyc < 120; cyc++) begin
            int  t;
            bit  pushing;
            t = cyc % 2;
            pushing = (cyc < 60) && !wr_full[t];
            if (pushing) begin
                push(1'(t), {6{3'd4}}, 6, wp[t]);
                for (int l = 0; l < 6; l++) begin
                    sb[t][wp[t]] = (wp[t] & 255);
                    wp[t]++;
                end
                cnt[t] += 6;
            end
            tick();
            idle();
            for (int s = 0; s < 4; s++) begin
                if (dec_vld[s]) begin
                    chk(int'(dec_data[s*8 +: 8]) == sb[dec_tid][rp[dec_tid]], "R3 fill order",
                        int'(dec_data[s*8 +: 8]), sb[dec_tid][rp[dec_tid]]);
                    rp[dec_tid]++;
                    cnt[dec_tid] -= 1;
                end
            end
            for (int tt = 0; tt < 2; tt++) begin
                chk(wr_full[tt] == (cnt[tt] >= 15), "R2 backpressure threshold",
                    int'(wr_full[tt]), int'(cnt[tt] >= 15));
            end
            if (wr_full[0]) sawbp = 1'b1;
        end
        chk(sawbp, "R2 threshold reached", int'(sawbp), 1);
        chk(cnt[0] == 0 && cnt[1] == 0, "R3 all records delivered", cnt[0] + cnt[1], 0);

        finish_run();
    end
endmodule